// File: doc/BRIEF.md
# Multiply-Accumulate Arithmetic Slice

This block is a pipelined arithmetic slice for datapaths that need multiply-add, accumulation, wide addition, bitwise logic or packed small-word arithmetic from one piece of hardware. An optional pre-adder sums D with the low 25 bits of A. The sum, or A alone, drives the 25-bit signed operand of a 25 x 18 multiplier whose other operand is B. A 48-bit post-stage combines three operands picked by an opcode bus. X chooses among zero, the multiplier result and the concatenation {A, B}. Y chooses among zero, the low partial product and all ones. Z chooses among zero, the accumulator P, C and P arithmetically shifted right by 17. The post-stage can add, subtract or apply a bitwise logic function, and it can be split into two 24-bit or four 12-bit lanes.

A pattern detector compares every new P with a constant under a mask. It reports a match, a match of the inverted pattern, and leaving either band (overflow and underflow). It can also clear the accumulator when a terminal count is reached. Input and pipeline registers can each be kept or bypassed by parameter. The output register is always present because it holds the accumulator. Each stage has its own clock enable, and one synchronous reset clears every stage.

Top module: `mac_slice`

## Requirements
- R1: With pre_add=0, opcode[1:0]=01 (X = multiplier), opcode[3:2]=00 and opcode[6:4]=011 (Z = C), P becomes C + signed(A[24:0]) * signed(B) in 48-bit two's complement.
- R2: With pre_add=1 the multiplier's 25-bit operand is (D + A[24:0]) mod 2^25, taken as signed.
- R3: X=01 together with Y (opcode[3:2])=01 carries the product as two parts, the product with bits 17:0 cleared on X and product bits 17:0 on Y, and their sum equals the full product. Y=01 without X=01 yields zero.
- R4: X codes: 00 zero, 01 multiplier, 11 {A,B}, 10 zero. Y codes: 00 zero, 01 low part, 10 all ones, 11 zero. Z codes (opcode[6:4]): 001 P, 011 C, 101 P arithmetically shifted right by 17; the other codes give zero.
- R5: alu_mode 0000 gives Z+X+Y+cin and 0001 gives Z-(X+Y+cin). The logic codes act on X and Z: 0100 AND, 0101 OR, 0110 NOT Z, 0111 NAND, 1000 NOR, 1001 XOR, 1010 XNOR, and all carry-outs are 0 under them. Every other code adds.
- R6: cin_sel picks the carry-in: 0 the carry_in pin, 1 constant one, 2 the inverted sign bit of P, 3 the sign bit of the multiplier result, 4 to 7 zero.
- R7: lane_mode 00 and 11 form one 48-bit lane with its carry on carry_out[3]. Mode 01 forms two 24-bit lanes with carries on carry_out[1] (low lane) and carry_out[3], and carry_out[0] and carry_out[2] stay at 0. Mode 10 forms four 12-bit lanes with carry_out[k] for lane k. No carry crosses a lane boundary, the carry-in enters only the lowest lane, and the multiplier result reads as zero in modes 01 and 10. A subtract lane computes Z + ~S + 1, where S = (X+Y+cin) modulo the lane width, and its carry-out is the carry of that sum.
- R8: pat_match is 1 when ((P xor PATTERN) and MASK) is zero. pat_match_inv is 1 when ((P xor ~PATTERN) and MASK) is zero.
- R9: overflow is 1 on a load where the previous P matched and the new P matches neither pattern. underflow is 1 on such a load where the previous P matched the inverted pattern.
- R10: When tc_clear is set for an operation and the current P matches the pattern, that load writes 0 to P and to the carries instead of the result.
- R11: With default parameters, inputs sampled at one rising edge reach P, carry_out and the flags at the third rising edge.
- R12: Reset clears P, carries, flags and both pipeline stages and wins over any clock enable. With ce_out low, P and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_in | input | 1 | Enable of the input stage |
| ce_mid | input | 1 | Enable of the multiplier stage |
| ce_out | input | 1 | Enable of the output stage |
| a | input | 30 | Operand A |
| b | input | 18 | Operand B |
| c | input | 48 | Operand C |
| d | input | 25 | Pre-adder operand D |
| opcode | input | 7 | X, Y and Z selects |
| alu_mode | input | 4 | Post-stage function |
| cin_sel | input | 3 | Carry-in source |
| lane_mode | input | 2 | Lane split |
| pre_add | input | 1 | Use D + A as the multiplier operand |
| carry_in | input | 1 | External carry-in |
| tc_clear | input | 1 | Clear P on a pattern match |
| p_out | output | 48 | Result and accumulator |
| carry_out | output | 4 | Lane carry-outs |
| pat_match | output | 1 | P matches pattern |
| pat_match_inv | output | 1 | P matches inverted pattern |
| overflow | output | 1 | Left the pattern band |
| underflow | output | 1 | Left the inverted band |

## Verification
Every result of this block (P, carries and the four flags) is due on the third rising edge after its operands and controls are sampled. This holds for feedback operations too, which read the P value present when their operation reaches the output stage. The bench model pushes each cycle's inputs into a two-entry queue and pops the entry sampled two edges earlier when it computes the next expected P, which gives the three-edge delay. It compares all outputs at the following falling edge. Clock-enable and reset-priority checks run with the model paused and compare P with the value captured one falling edge earlier.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [3:0] {
        ALU_ADD  = 4'b0000,
        ALU_SUB  = 4'b0001,
        ALU_AND  = 4'b0100,
        ALU_OR   = 4'b0101,
        ALU_NOT  = 4'b0110,
        ALU_NAND = 4'b0111,
        ALU_NOR  = 4'b1000,
        ALU_XOR  = 4'b1001,
        ALU_XNOR = 4'b1010
    } alu_op_e;

    typedef struct packed {
        logic [6:0] opc;
        logic [3:0] alu;
        logic [2:0] cin_sel;
        logic [1:0] lanes;
        logic       pre_add;
        logic       cin;
        logic       tc_clr;
    } mac_ctrl_t;

endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (EN) begin : g_reg
        logic [W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)     r <= '0;
            else if (ce) r <= d;
        end
        assign q = r;
    end else begin : g_thru
        assign q = d;
    end
endmodule

// File: rtl/mac_lane_adder.sv
module mac_lane_adder #(
    parameter int W = 12
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         co
);
    logic [W-1:0] s;
    logic [W:0]   t;

    always_comb begin
        s = x + y + W'(cin);
        if (sub) t = {1'b0, z} + {1'b0, ~s} + (W+1)'(1);
        else     t = {1'b0, z} + {1'b0, s};
    end

    assign r  = t[W-1:0];
    assign co = t[W];
endmodule

// File: rtl/mac_post.sv
module mac_post
    import mac_pkg::*;
#(
    parameter int PW     = 48,
    parameter int PSPLIT = 18,
    parameter int SHIFT  = 17
) (
    input  logic [PW-1:0] m,
    input  logic [PW-1:0] ab,
    input  logic [PW-1:0] c,
    input  logic [PW-1:0] p_fb,
    input  mac_ctrl_t     ctrl,
    output logic [PW-1:0] res,
    output logic [3:0]    cout
);
    localparam int HALF = PW / 2;
    localparam int QTR  = PW / 4;

    logic [PW-1:0] mz, xv, yv, zv, r_full, r_dual, r_quad, ar;
    logic          simd, cin_v, sub, co_full;
    logic [1:0]    co_dual;
    logic [3:0]    co_quad, ac;

    assign simd = (ctrl.lanes == 2'b01) || (ctrl.lanes == 2'b10);
    assign mz   = simd ? '0 : m;
    assign sub  = (ctrl.alu == ALU_SUB);

    always_comb begin
        case (ctrl.opc[1:0])
            2'b01:   xv = (ctrl.opc[3:2] == 2'b01) ? {mz[PW-1:PSPLIT], {PSPLIT{1'b0}}} : mz;
            2'b11:   xv = ab;
            default: xv = '0;
        endcase
        case (ctrl.opc[3:2])
            2'b01:   yv = (ctrl.opc[1:0] == 2'b01) ? {{(PW-PSPLIT){1'b0}}, mz[PSPLIT-1:0]} : '0;
            2'b10:   yv = '1;
            default: yv = '0;
        endcase
        case (ctrl.opc[6:4])
            3'b001:  zv = p_fb;
            3'b011:  zv = c;
            3'b101:  zv = {{SHIFT{p_fb[PW-1]}}, p_fb[PW-1:SHIFT]};
            default: zv = '0;
        endcase
        case (ctrl.cin_sel)
            3'd0:    cin_v = ctrl.cin;
            3'd1:    cin_v = 1'b1;
            3'd2:    cin_v = ~p_fb[PW-1];
            3'd3:    cin_v = mz[PW-1];
            default: cin_v = 1'b0;
        endcase
    end

    mac_lane_adder #(.W(PW)) u_full (
        .x(xv), .y(yv), .z(zv), .cin(cin_v), .sub(sub), .r(r_full), .co(co_full)
    );

    for (genvar k = 0; k < 2; k++) begin : g_dual
        mac_lane_adder #(.W(HALF)) u_add (
            .x(xv[k*HALF +: HALF]), .y(yv[k*HALF +: HALF]), .z(zv[k*HALF +: HALF]),
            .cin((k == 0) ? cin_v : 1'b0), .sub(sub),
            .r(r_dual[k*HALF +: HALF]), .co(co_dual[k])
        );
    end

    for (genvar k = 0; k < 4; k++) begin : g_quad
        mac_lane_adder #(.W(QTR)) u_add (
            .x(xv[k*QTR +: QTR]), .y(yv[k*QTR +: QTR]), .z(zv[k*QTR +: QTR]),
            .cin((k == 0) ? cin_v : 1'b0), .sub(sub),
            .r(r_quad[k*QTR +: QTR]), .co(co_quad[k])
        );
    end

    always_comb begin
        case (ctrl.lanes)
            2'b01: begin
                ar = r_dual;
                ac = {co_dual[1], 1'b0, co_dual[0], 1'b0};
            end
            2'b10: begin
                ar = r_quad;
                ac = co_quad;
            end
            default: begin
                ar = r_full;
                ac = {co_full, 3'b000};
            end
        endcase
        cout = 4'b0000;
        case (ctrl.alu)
            ALU_AND:  res = xv & zv;
            ALU_OR:   res = xv | zv;
            ALU_NOT:  res = ~zv;
            ALU_NAND: res = ~(xv & zv);
            ALU_NOR:  res = ~(xv | zv);
            ALU_XOR:  res = xv ^ zv;
            ALU_XNOR: res = ~(xv ^ zv);
            default: begin
                res  = ar;
                cout = ac;
            end
        endcase
    end
endmodule

// File: rtl/mac_slice.sv
module mac_slice
    import mac_pkg::*;
#(
    parameter int          AW      = 30,
    parameter int          BW      = 18,
    parameter int          CW      = 48,
    parameter int          DW      = 25,
    parameter int          PW      = 48,
    parameter bit          IN_REG  = 1'b1,
    parameter bit          MID_REG = 1'b1,
    parameter logic [47:0] PATTERN = 48'h0,
    parameter logic [47:0] MASK    = 48'hFFFF_FFFF_FFFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_in,
    input  logic          ce_mid,
    input  logic          ce_out,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic [CW-1:0] c,
    input  logic [DW-1:0] d,
    input  logic [6:0]    opcode,
    input  logic [3:0]    alu_mode,
    input  logic [2:0]    cin_sel,
    input  logic [1:0]    lane_mode,
    input  logic          pre_add,
    input  logic          carry_in,
    input  logic          tc_clear,
    output logic [PW-1:0] p_out,
    output logic [3:0]    carry_out,
    output logic          pat_match,
    output logic          pat_match_inv,
    output logic          overflow,
    output logic          underflow
);
    localparam int CTW   = $bits(mac_ctrl_t);
    localparam int PRODW = DW + BW;
    localparam int S1W   = AW + BW + CW + DW + CTW;
    localparam int S2W   = PW + AW + BW + CW + CTW;

    mac_ctrl_t           ctrl_in, ctrl1, ctrl_s2;
    logic [S1W-1:0]      s1_d, s1_q;
    logic [S2W-1:0]      s2_d, s2_q;
    logic [AW-1:0]       a1;
    logic [BW-1:0]       b1;
    logic [CW-1:0]       c1, c2;
    logic [DW-1:0]       d1, pre_val;
    logic signed [PRODW-1:0] prod;
    logic [PW-1:0]       m1, m2, ab2, res, p_new;
    logic [3:0]          cout, co_new;
    logic                hit, hit_inv;

    always_comb begin
        ctrl_in = '{opc: opcode, alu: alu_mode, cin_sel: cin_sel, lanes: lane_mode,
                    pre_add: pre_add, cin: carry_in, tc_clr: tc_clear};
    end

    // stage 1: operand and control capture
    assign s1_d = {a, b, c, d, ctrl_in};
    mac_pipe_reg #(.W(S1W), .EN(IN_REG)) u_stage_in (
        .clk(clk), .rst(rst), .ce(ce_in), .d(s1_d), .q(s1_q)
    );
    assign {a1, b1, c1, d1, ctrl1} = s1_q;

    // stage 2: pre-adder and signed multiplier
    assign pre_val = ctrl1.pre_add ? (d1 + a1[DW-1:0]) : a1[DW-1:0];
    assign prod    = $signed(pre_val) * $signed(b1);
    assign m1      = {{(PW-PRODW){prod[PRODW-1]}}, prod};
    assign s2_d    = {m1, a1, b1, c1, ctrl1};
    mac_pipe_reg #(.W(S2W), .EN(MID_REG)) u_stage_mid (
        .clk(clk), .rst(rst), .ce(ce_mid), .d(s2_d), .q(s2_q)
    );
    assign {m2, ab2, c2, ctrl_s2} = s2_q;

    // stage 3: operand muxes, adder lanes and logic unit
    mac_post #(.PW(PW)) u_post (
        .m(m2), .ab(ab2), .c(c2), .p_fb(p_out), .ctrl(ctrl_s2), .res(res), .cout(cout)
    );

    always_comb begin
        if (ctrl_s2.tc_clr && pat_match) begin
            p_new  = '0;
            co_new = 4'b0000;
        end else begin
            p_new  = res;
            co_new = cout;
        end
        hit     = ((p_new ^ PATTERN) & MASK) == '0;
        hit_inv = ((p_new ^ ~PATTERN) & MASK) == '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_out         <= '0;
            carry_out     <= '0;
            pat_match     <= 1'b0;
            pat_match_inv <= 1'b0;
            overflow      <= 1'b0;
            underflow     <= 1'b0;
        end else if (ce_out) begin
            p_out         <= p_new;
            carry_out     <= co_new;
            pat_match     <= hit;
            pat_match_inv <= hit_inv;
            overflow      <= pat_match && !hit && !hit_inv;
            underflow     <= pat_match_inv && !hit && !hit_inv;
        end
    end
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk
    import mac_pkg::*;
#(
    parameter int          PW   = 48,
    parameter logic [47:0] MASK = 48'hFFFF_FFFF_FFFF
) (
    input logic          clk,
    input logic          rst,
    input logic          ce_out,
    input mac_ctrl_t     ctrl_s2,
    input logic [PW-1:0] p_out,
    input logic [3:0]    carry_out,
    input logic          pat_match,
    input logic          pat_match_inv,
    input logic          overflow,
    input logic          underflow
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (p_out == '0 && carry_out == '0 && !pat_match && !pat_match_inv && !overflow && !underflow)); // R12
    AST_CE_HOLDS_P: assert property (@(posedge clk) disable iff (rst) !ce_out |=> ($stable(p_out) && $stable(pat_match))); // R12
    AST_DUAL_LANE_CARRY: assert property (@(posedge clk) disable iff (rst) (ce_out && ctrl_s2.lanes == 2'b01) |=> (carry_out[0] == 1'b0 && carry_out[2] == 1'b0)); // R7
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst) (ce_out && ctrl_s2.alu >= 4'd4 && ctrl_s2.alu <= 4'd10) |=> carry_out == 4'b0000); // R5
    AST_TC_CLEAR: assert property (@(posedge clk) disable iff (rst) (ce_out && ctrl_s2.tc_clr && pat_match) |=> p_out == '0); // R10
    AST_OVERFLOW_AFTER_MATCH: assert property (@(posedge clk) disable iff (rst) $rose(overflow) |-> $past(pat_match)); // R9
    AST_UNDERFLOW_AFTER_INV: assert property (@(posedge clk) disable iff (rst) $rose(underflow) |-> $past(pat_match_inv)); // R9
    if (MASK != '0) begin : g_excl
        AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({pat_match, pat_match_inv})); // R8
    end
endmodule

bind mac_slice mac_slice_chk #(.PW(PW), .MASK(MASK)) u_mac_slice_chk (
    .clk(clk), .rst(rst), .ce_out(ce_out), .ctrl_s2(ctrl_s2), .p_out(p_out),
    .carry_out(carry_out), .pat_match(pat_match), .pat_match_inv(pat_match_inv),
    .overflow(overflow), .underflow(underflow)
);

// File: tb/test_mac_slice.sv
module test_mac_slice;
    localparam logic [47:0] PAT = 48'h0000_0000_0060;
    localparam logic [47:0] MSK = 48'hFFFF_FFFF_FFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_in = 1'b1, ce_mid = 1'b1, ce_out = 1'b1;
    logic [29:0] a = '0;
    logic [17:0] b = '0;
    logic [47:0] c = '0;
    logic [24:0] d = '0;
    logic [6:0]  opcode = '0;
    logic [3:0]  alu_mode = '0;
    logic [2:0]  cin_sel = '0;
    logic [1:0]  lane_mode = '0;
    logic        pre_add = 1'b0, carry_in = 1'b0, tc_clear = 1'b0;
    logic [47:0] p_out;
    logic [3:0]  carry_out;
    logic        pat_match, pat_match_inv, overflow, underflow;

    int    checks = 0;
    int    errors = 0;
    bit    model_on = 1'b0;
    string cur_req = "R12";

    mac_slice #(.PATTERN(PAT), .MASK(MSK)) i_mac_slice (
        .clk(clk), .rst(rst), .ce_in(ce_in), .ce_mid(ce_mid), .ce_out(ce_out),
        .a(a), .b(b), .c(c), .d(d), .opcode(opcode), .alu_mode(alu_mode),
        .cin_sel(cin_sel), .lane_mode(lane_mode), .pre_add(pre_add),
        .carry_in(carry_in), .tc_clear(tc_clear), .p_out(p_out),
        .carry_out(carry_out), .pat_match(pat_match), .pat_match_inv(pat_match_inv),
        .overflow(overflow), .underflow(underflow)
    );

    always #2ns clk = ~clk;

    typedef struct {
        logic [29:0] a; logic [17:0] b; logic [47:0] c; logic [24:0] d;
        logic [6:0] op; logic [3:0] alu; logic [2:0] cs; logic [1:0] ln;
        logic pre, ci, tc;
    } rec_t;

    rec_t        q[$];
    logic [47:0] ep = '0;
    logic [3:0]  ec = '0;
    logic        em = 1'b0, ei = 1'b0, eo = 1'b0, eu = 1'b0;

    function automatic void model_step(rec_t o);
        logic [24:0] pv;
        logic signed [47:0] pr;
        logic [47:0] mp, x, y, z, res;
        logic [63:0] msk, xl, yl, zl, s, t, sh;
        logic [3:0]  co;
        logic        cin, hit, hinv;
        int nl, w;
        pv = o.pre ? o.d + o.a[24:0] : o.a[24:0];
        pr = $signed(pv) * $signed(o.b);
        mp = (o.ln == 2'd1 || o.ln == 2'd2) ? 48'h0 : pr;
        case (o.op[1:0])
            2'd1:    x = (o.op[3:2] == 2'd1) ? (mp & ~48'h3FFFF) : mp;
            2'd3:    x = {o.a, o.b};
            default: x = '0;
        endcase
        case (o.op[3:2])
            2'd1:    y = (o.op[1:0] == 2'd1) ? (mp & 48'h3FFFF) : 48'h0;
            2'd2:    y = '1;
            default: y = '0;
        endcase
        case (o.op[6:4])
            3'd1:    z = ep;
            3'd3:    z = o.c;
            3'd5:    z = $signed(ep) >>> 17;
            default: z = '0;
        endcase
        case (o.cs)
            3'd0:    cin = o.ci;
            3'd1:    cin = 1'b1;
            3'd2:    cin = ~ep[47];
            3'd3:    cin = mp[47];
            default: cin = 1'b0;
        endcase
        co = 4'b0;
        case (o.alu)
            4'd4:  res = x & z;
            4'd5:  res = x | z;
            4'd6:  res = ~z;
            4'd7:  res = ~(x & z);
            4'd8:  res = ~(x | z);
            4'd9:  res = x ^ z;
            4'd10: res = ~(x ^ z);
            default: begin
                nl = (o.ln == 2'd1) ? 2 : ((o.ln == 2'd2) ? 4 : 1);
                w = 48 / nl;
                msk = (64'd1 << w) - 64'd1;
                res = '0;
                for (int k = 0; k < nl; k++) begin
                    xl = ({16'h0, x} >> (k * w)) & msk;
                    yl = ({16'h0, y} >> (k * w)) & msk;
                    zl = ({16'h0, z} >> (k * w)) & msk;
                    s  = (xl + yl + ((k == 0) ? {63'h0, cin} : 64'h0)) & msk;
                    t  = (o.alu == 4'd1) ? (zl + (~s & msk) + 64'd1) : (zl + s);
                    sh = (t & msk) << (k * w);
                    res = res | sh[47:0];
                    co[(k + 1) * (4 / nl) - 1] = t[w];
                end
            end
        endcase
        if (o.tc && em) begin
            res = '0;
            co  = 4'b0;
        end
        hit  = ((res ^ PAT) & MSK) == 48'h0;
        hinv = ((res ^ ~PAT) & MSK) == 48'h0;
        eo = em && !hit && !hinv;
        eu = ei && !hit && !hinv;
        em = hit;
        ei = hinv;
        ep = res;
        ec = co;
    endfunction

    always @(posedge clk) begin
        rec_t r, o, zr;
        r = '{a: a, b: b, c: c, d: d, op: opcode, alu: alu_mode, cs: cin_sel, ln: lane_mode,
              pre: pre_add, ci: carry_in, tc: tc_clear};
        zr = '{a: '0, b: '0, c: '0, d: '0, op: '0, alu: '0, cs: '0, ln: '0,
               pre: 1'b0, ci: 1'b0, tc: 1'b0};
        if (rst) begin
            ep = '0; ec = '0; em = 1'b0; ei = 1'b0; eo = 1'b0; eu = 1'b0;
            q.delete();
            q.push_back(zr);
            q.push_back(zr);
        end else if (q.size() == 2) begin
            o = q.pop_front();
            model_step(o);
            q.push_back(r);
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            checks++;
            if (p_out !== ep || carry_out !== ec || pat_match !== em || pat_match_inv !== ei ||
                overflow !== eo || underflow !== eu) begin
                errors++;
                $display("FAIL %s: p=%h exp=%h carry=%b exp=%b flags(m,i,o,u)=%b%b%b%b exp=%b%b%b%b",
                         cur_req, p_out, ep, carry_out, ec, pat_match, pat_match_inv, overflow,
                         underflow, em, ei, eo, eu);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rnd_ops();
        logic [63:0] r64;
        r64 = {$urandom(), $urandom()};
        c = r64[47:0];
        r64 = {$urandom(), $urandom()};
        a = r64[29:0];
        b = r64[47:30];
        d = r64[63:39];
        carry_in = r64[0];
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_reset();
        rst = 1'b1;
        cycles(2);
        rst = 1'b0;
    endtask

    initial begin
        #400us;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] held;
        cycles(3);
        model_on = 1'b1;
        cur_req = "R12";                         // reset state
        cycles(2);
        rst = 1'b0;

        cur_req = "R1";                          // C + A*B
        opcode = 7'b011_00_01;
        for (int i = 0; i < 20; i++) begin rnd_ops(); cycles(1); end

        cur_req = "R2";                          // pre-adder
        pre_add = 1'b1;
        for (int i = 0; i < 20; i++) begin rnd_ops(); cycles(1); end
        pre_add = 1'b0;

        cur_req = "R3";                          // partial products
        opcode = 7'b011_01_01;
        for (int i = 0; i < 15; i++) begin rnd_ops(); cycles(1); end
        opcode = 7'b011_01_00;
        for (int i = 0; i < 5; i++) begin rnd_ops(); cycles(1); end

        cur_req = "R4";                          // operand selects
        opcode = 7'b001_00_11;
        for (int i = 0; i < 10; i++) begin rnd_ops(); cycles(1); end
        opcode = 7'b011_10_00;
        for (int i = 0; i < 5; i++) begin rnd_ops(); cycles(1); end
        opcode = 7'b101_00_11;
        for (int i = 0; i < 10; i++) begin rnd_ops(); cycles(1); end
        for (int i = 0; i < 30; i++) begin
            rnd_ops();
            opcode = 7'($urandom());
            alu_mode = {3'b000, 1'($urandom())};
            cycles(1);
        end

        cur_req = "R5";                          // add, subtract, logic
        opcode = 7'b011_00_11;
        for (int m = 0; m < 16; m++) begin
            alu_mode = 4'(m);
            for (int i = 0; i < 3; i++) begin rnd_ops(); cycles(1); end
        end
        alu_mode = 4'd0;

        cur_req = "R6";                          // carry-in sources
        for (int s = 0; s < 8; s++) begin
            cin_sel = 3'(s);
            opcode = (s == 2) ? 7'b001_00_11 : 7'b011_00_01;
            for (int i = 0; i < 3; i++) begin rnd_ops(); cycles(1); end
        end
        cin_sel = 3'd0;

        cur_req = "R7";                          // lane split
        for (int l = 1; l < 4; l++) begin
            lane_mode = 2'(l);
            for (int i = 0; i < 12; i++) begin
                rnd_ops();
                opcode = (i < 3) ? 7'b011_00_01 : 7'b011_00_11;
                alu_mode = {3'b000, 1'(i % 2)};
                cycles(1);
            end
            opcode = 7'b011_00_11; alu_mode = 4'd0; cin_sel = 3'd1;
            a = '1; b = '1; c = 48'h1;
            cycles(1);
            alu_mode = 4'd1; a = '0; b = 18'h1; c = '0;
            cycles(1);
            cin_sel = 3'd0; alu_mode = 4'd0;
        end
        lane_mode = 2'd0;

        cur_req = "R11";                         // latency impulse
        opcode = 7'b011_00_11; c = '0; a = '0; b = 18'd5;
        cycles(1);
        b = '0;
        cycles(5);

        cur_req = "R8";                          // count up through the band
        pulse_reset();
        opcode = 7'b001_00_11; a = '0; b = 18'd8; c = '0; carry_in = 1'b0;
        cycles(14);
        cur_req = "R9";
        cycles(8);
        pulse_reset();
        alu_mode = 4'd1;                         // count down through inverted band
        cycles(20);
        alu_mode = 4'd0;

        cur_req = "R10";                         // terminal count clear
        pulse_reset();
        tc_clear = 1'b1;
        cycles(40);
        tc_clear = 1'b0;

        model_on = 1'b0;                         // R12 enable hold and reset priority
        pulse_reset();
        cycles(6);
        ce_out = 1'b0;
        cycles(1);
        held = p_out;
        for (int i = 0; i < 3; i++) begin
            cycles(1);
            check(p_out == held, "R12 hold", p_out, held);
        end
        ce_in = 1'b0; ce_mid = 1'b0;
        rst = 1'b1;
        cycles(1);
        check(p_out == '0 && carry_out == '0 && !pat_match, "R12 reset priority", p_out, 48'h0);
        ce_in = 1'b1; ce_mid = 1'b1; ce_out = 1'b1;
        cycles(1);
        rst = 1'b0;
        cycles(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule